// File: doc/BRIEF.md
# Transactional Conflict Age Arbiter

This block sits beside the coherence controller of a processor node that runs hardware transactions on several threads. When the node refuses (NACKs) a remote request, or has its own request refused, the block decides from transaction age whether a deadlock cycle may be forming. Age is taken from a nonzero start timestamp per transaction. Ties are broken first by thread index, when both sides are on the same processor, and then by processor number.

When the node refuses a request from an older remote transaction, every local thread whose read set or write set holds the line is marked with a possible-cycle flag. If a marked thread is later refused by an older transaction, the block raises a trap request for that thread, so that software can break the cycle. Each receive event also records, for the refused thread, whom it waits on: the remote logical thread number and the remote timestamp. The flags and the record stay set until a per-thread end pulse clears them. An event that carries a zero timestamp is illegal. It is rejected and reported on an error pulse.

Top module: `txn_age_arbiter`

## Requirements
- R1: During and right after reset, the possible-cycle, trap, wait-valid, wait-id, wait-timestamp and error outputs are all zero.
- R2: The remote side is older when its timestamp is strictly smaller than the thread's local timestamp. It is younger when its timestamp is strictly larger.
- R3: On equal timestamps with a remote processor number equal to LOCAL_PROC, the remote side is older exactly when its thread index is smaller than the local thread index.
- R4: On equal timestamps with a different processor number, the remote side is older exactly when its processor number is smaller than LOCAL_PROC.
- R5: A send-NACK strobe sets the possible-cycle bit of every thread t whose read-hit bit t or write-hit bit t is 1 and for which the remote side is older. No other bit changes.
- R6: A receive-NACK strobe for thread index rcv_tid sets that thread's wait-valid bit. It stores the wait id rem_proc*NUM_THREADS+rem_tid in slice [t*LID_W +: LID_W] of wait_id_o, and rem_ts in slice [t*TS_W +: TS_W] of wait_ts_o. Other threads are not touched.
- R7: A receive-NACK sets the thread's trap bit only when its possible-cycle bit was already 1 before that cycle and the remote side is older. A send-NACK in the same cycle does not count as already set.
- R8: A strobe whose remote timestamp is zero, or that selects a thread whose local timestamp is zero, changes no state. It raises ts_err_o for exactly one cycle after the strobe. ts_err_o is 0 after any cycle with no strobe.
- R9: A txn_end_i bit clears that thread's possible-cycle, trap and wait-valid bits. It wins over any event in the same cycle.
- R10: All outputs are registered. An event becomes visible after the next rising clock edge, and the flags hold until R9 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| local_ts_i | input | NUM_THREADS*TS_W | Local transaction timestamp per thread, thread t in slice t |
| rem_ts_i | input | TS_W | Timestamp of the remote transaction |
| rem_proc_i | input | PROC_W | Processor number of the remote side |
| rem_tid_i | input | TID_W | Thread index of the remote side |
| rd_hit_i | input | NUM_THREADS | Line found in the thread's read set |
| wr_hit_i | input | NUM_THREADS | Line found in the thread's write set |
| snd_nack_i | input | 1 | Single-cycle strobe: this node refused a remote request |
| rcv_nack_i | input | 1 | Single-cycle strobe: a local thread was refused |
| rcv_tid_i | input | TID_W | Local thread that was refused |
| txn_end_i | input | NUM_THREADS | Per-thread end/abort pulse |
| cycle_o | output | NUM_THREADS | Possible-cycle flags |
| trap_o | output | NUM_THREADS | Trap request flags |
| wait_valid_o | output | NUM_THREADS | Wait-on record valid per thread |
| wait_id_o | output | NUM_THREADS*LID_W | Remote logical thread waited on |
| wait_ts_o | output | NUM_THREADS*TS_W | Remote timestamp waited on |
| ts_err_o | output | 1 | Illegal zero timestamp seen on the previous strobe |

## Verification
The bench builds the block with four threads, 8-bit timestamps, 3-bit processor numbers and LOCAL_PROC set to 5. With that setting, remote processors both below and above the local one can be driven, so both outcomes of the processor tie-break are reached. The default LOCAL_PROC of 0 could never reach the "remote smaller" outcome. Four threads let a single strobe give a mix of older and younger results across threads. Narrow timestamps make the equal-timestamp and zero-timestamp cases cheap to hit.

// File: rtl/txn_arb_pkg.sv
package txn_arb_pkg;

    localparam int unsigned DEF_THREADS = 4;
    localparam int unsigned DEF_TS_W    = 32;
    localparam int unsigned DEF_PROC_W  = 4;

    // result of one age comparison, seen from the local thread
    typedef enum logic [1:0] {
        AGE_YOUNGER = 2'd0,
        AGE_OLDER   = 2'd1,
        AGE_SAME    = 2'd2
    } age_e;

    function automatic int unsigned tid_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/txn_age_cmp.sv
module txn_age_cmp
    import txn_arb_pkg::*;
#(
    parameter int unsigned TS_W       = DEF_TS_W,
    parameter int unsigned PROC_W     = DEF_PROC_W,
    parameter int unsigned TID_W      = 2,
    parameter int unsigned LOCAL_PROC = 0,
    parameter int unsigned LOCAL_TID  = 0
) (
    input  logic [TS_W-1:0]   local_ts_i,
    input  logic [TS_W-1:0]   rem_ts_i,
    input  logic [PROC_W-1:0] rem_proc_i,
    input  logic [TID_W-1:0]  rem_tid_i,
    output age_e              age_o,
    output logic              local_zero_o
);

    localparam logic [PROC_W-1:0] MY_PROC = PROC_W'(LOCAL_PROC);
    localparam logic [TID_W-1:0]  MY_TID  = TID_W'(LOCAL_TID);

    always_comb begin
        if (rem_ts_i < local_ts_i) begin
            age_o = AGE_OLDER;
        end else if (rem_ts_i > local_ts_i) begin
            age_o = AGE_YOUNGER;
        end else if (rem_proc_i == MY_PROC) begin
            // same processor: thread index decides
            if (rem_tid_i < MY_TID) begin
                age_o = AGE_OLDER;
            end else if (rem_tid_i == MY_TID) begin
                age_o = AGE_SAME;
            end else begin
                age_o = AGE_YOUNGER;
            end
        end else if (rem_proc_i < MY_PROC) begin
            age_o = AGE_OLDER;
        end else begin
            age_o = AGE_YOUNGER;
        end
    end

    assign local_zero_o = (local_ts_i == '0);

endmodule

// File: rtl/txn_evt_qual.sv
module txn_evt_qual #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned TS_W        = 32
) (
    input  logic                   snd_nack_i,
    input  logic                   rcv_nack_i,
    input  logic [TID_W-1:0]       rcv_tid_i,
    input  logic [NUM_THREADS-1:0] rd_hit_i,
    input  logic [NUM_THREADS-1:0] wr_hit_i,
    input  logic [TS_W-1:0]        rem_ts_i,
    input  logic [NUM_THREADS-1:0] local_zero_i,
    output logic [NUM_THREADS-1:0] snd_sel_o,
    output logic [NUM_THREADS-1:0] rcv_sel_o,
    output logic                   evt_ok_o,
    output logic                   evt_bad_o
);

    logic rem_zero;
    logic any_evt;
    logic local_bad;

    assign snd_sel_o = {NUM_THREADS{snd_nack_i}} & (rd_hit_i | wr_hit_i);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_rcv
        assign rcv_sel_o[t] = rcv_nack_i && (rcv_tid_i == TID_W'(t));
    end

    assign rem_zero  = (rem_ts_i == '0);
    assign any_evt   = snd_nack_i | rcv_nack_i;
    assign local_bad = |((snd_sel_o | rcv_sel_o) & local_zero_i);
    assign evt_bad_o = (any_evt && rem_zero) || local_bad;
    assign evt_ok_o  = !evt_bad_o;

endmodule

// File: rtl/txn_thread_ctx.sv
module txn_thread_ctx
    import txn_arb_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TS_W        = DEF_TS_W,
    parameter int unsigned PROC_W      = DEF_PROC_W,
    parameter int unsigned TID_W       = 2,
    parameter int unsigned LID_W       = 6,
    parameter int unsigned LOCAL_PROC  = 0,
    parameter int unsigned THREAD_IDX  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   local_ts_i,
    input  logic [TS_W-1:0]   rem_ts_i,
    input  logic [PROC_W-1:0] rem_proc_i,
    input  logic [TID_W-1:0]  rem_tid_i,
    input  logic              snd_sel_i,
    input  logic              rcv_sel_i,
    input  logic              evt_ok_i,
    input  logic              end_i,
    output logic              local_zero_o,
    output logic              cycle_o,
    output logic              trap_o,
    output logic              wvalid_o,
    output logic [LID_W-1:0]  wid_o,
    output logic [TS_W-1:0]   wts_o
);

    typedef struct packed {
        logic             cyc;
        logic             trap;
        logic             wvalid;
        logic [LID_W-1:0] wid;
        logic [TS_W-1:0]  wts;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    age_e age;
    logic rem_older;
    logic [LID_W-1:0] rem_lid;

    txn_age_cmp #(
        .TS_W      (TS_W),
        .PROC_W    (PROC_W),
        .TID_W     (TID_W),
        .LOCAL_PROC(LOCAL_PROC),
        .LOCAL_TID (THREAD_IDX)
    ) u_cmp (
        .local_ts_i  (local_ts_i),
        .rem_ts_i    (rem_ts_i),
        .rem_proc_i  (rem_proc_i),
        .rem_tid_i   (rem_tid_i),
        .age_o       (age),
        .local_zero_o(local_zero_o)
    );

    assign rem_older = (age == AGE_OLDER);
    assign rem_lid   = LID_W'(rem_proc_i) * LID_W'(NUM_THREADS) + LID_W'(rem_tid_i);

    always_comb begin
        ctx_d = ctx_q;
        if (end_i) begin
            ctx_d.cyc    = 1'b0;
            ctx_d.trap   = 1'b0;
            ctx_d.wvalid = 1'b0;
        end else if (evt_ok_i) begin
            if (snd_sel_i && rem_older) begin
                ctx_d.cyc = 1'b1;
            end
            if (rcv_sel_i) begin
                ctx_d.wvalid = 1'b1;
                ctx_d.wid    = rem_lid;
                ctx_d.wts    = rem_ts_i;
                // only a flag held from an earlier cycle arms the trap
                if (ctx_q.cyc && rem_older) begin
                    ctx_d.trap = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cycle_o  = ctx_q.cyc;
    assign trap_o   = ctx_q.trap;
    assign wvalid_o = ctx_q.wvalid;
    assign wid_o    = ctx_q.wid;
    assign wts_o    = ctx_q.wts;

endmodule

// File: rtl/txn_age_arbiter.sv
module txn_age_arbiter
    import txn_arb_pkg::*;
#(
    parameter int unsigned NUM_THREADS = DEF_THREADS,
    parameter int unsigned TS_W        = DEF_TS_W,
    parameter int unsigned PROC_W      = DEF_PROC_W,
    parameter int unsigned LOCAL_PROC  = 0,
    parameter int unsigned TID_W       = tid_width(NUM_THREADS),
    parameter int unsigned LID_W       = PROC_W + TID_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_THREADS*TS_W-1:0]  local_ts_i,
    input  logic [TS_W-1:0]              rem_ts_i,
    input  logic [PROC_W-1:0]            rem_proc_i,
    input  logic [TID_W-1:0]             rem_tid_i,
    input  logic [NUM_THREADS-1:0]       rd_hit_i,
    input  logic [NUM_THREADS-1:0]       wr_hit_i,
    input  logic                         snd_nack_i,
    input  logic                         rcv_nack_i,
    input  logic [TID_W-1:0]             rcv_tid_i,
    input  logic [NUM_THREADS-1:0]       txn_end_i,
    output logic [NUM_THREADS-1:0]       cycle_o,
    output logic [NUM_THREADS-1:0]       trap_o,
    output logic [NUM_THREADS-1:0]       wait_valid_o,
    output logic [NUM_THREADS*LID_W-1:0] wait_id_o,
    output logic [NUM_THREADS*TS_W-1:0]  wait_ts_o,
    output logic                         ts_err_o
);

    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_THREADS-1:0] snd_sel;
    logic [NUM_THREADS-1:0] rcv_sel;
    logic [NUM_THREADS-1:0] local_zero;
    logic                   evt_ok;
    logic                   evt_bad;

    txn_evt_qual #(
        .NUM_THREADS(NUM_THREADS),
        .TID_W      (TID_W),
        .TS_W       (TS_W)
    ) u_qual (
        .snd_nack_i  (snd_nack_i),
        .rcv_nack_i  (rcv_nack_i),
        .rcv_tid_i   (rcv_tid_i),
        .rd_hit_i    (rd_hit_i),
        .wr_hit_i    (wr_hit_i),
        .rem_ts_i    (rem_ts_i),
        .local_zero_i(local_zero),
        .snd_sel_o   (snd_sel),
        .rcv_sel_o   (rcv_sel),
        .evt_ok_o    (evt_ok),
        .evt_bad_o   (evt_bad)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        txn_thread_ctx #(
            .NUM_THREADS(NUM_THREADS),
            .TS_W       (TS_W),
            .PROC_W     (PROC_W),
            .TID_W      (TID_W),
            .LID_W      (LID_W),
            .LOCAL_PROC (LOCAL_PROC),
            .THREAD_IDX (t)
        ) u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .local_ts_i  (local_ts_i[t*TS_W +: TS_W]),
            .rem_ts_i    (rem_ts_i),
            .rem_proc_i  (rem_proc_i),
            .rem_tid_i   (rem_tid_i),
            .snd_sel_i   (snd_sel[t]),
            .rcv_sel_i   (rcv_sel[t]),
            .evt_ok_i    (evt_ok),
            .end_i       (txn_end_i[t]),
            .local_zero_o(local_zero[t]),
            .cycle_o     (cycle_o[t]),
            .trap_o      (trap_o[t]),
            .wvalid_o    (wait_valid_o[t]),
            .wid_o       (wait_id_o[t*LID_W +: LID_W]),
            .wts_o       (wait_ts_o[t*TS_W +: TS_W])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.err = evt_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign ts_err_o = top_q.err;

endmodule

// File: rtl/txn_age_arbiter_chk.sv
module txn_age_arbiter_chk #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned TS_W        = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [TS_W-1:0]        rem_ts_i,
    input logic                   snd_nack_i,
    input logic                   rcv_nack_i,
    input logic [NUM_THREADS-1:0] txn_end_i,
    input logic [NUM_THREADS-1:0] cycle_o,
    input logic [NUM_THREADS-1:0] trap_o,
    input logic [NUM_THREADS-1:0] wait_valid_o,
    input logic                   ts_err_o
);

    AST_ERR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_nack_i || rcv_nack_i) && rem_ts_i == '0 |=> ts_err_o); // R8

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_nack_i && !rcv_nack_i |=> !ts_err_o); // R8

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end_i != '0 |=> ((cycle_o | trap_o | wait_valid_o) & $past(txn_end_i)) == '0); // R9

    AST_TRAP_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((trap_o & ~$past(trap_o)) & ~$past(cycle_o)) == '0); // R7

    AST_CYCLE_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o & ~$past(cycle_o)) != '0 |-> $past(snd_nack_i)); // R5

    AST_ONE_WAIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wait_valid_o & ~$past(wait_valid_o)) <= 1); // R6

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_nack_i && !rcv_nack_i && txn_end_i == '0
        |=> $stable(cycle_o) && $stable(trap_o) && $stable(wait_valid_o)); // R10

endmodule

bind txn_age_arbiter txn_age_arbiter_chk #(
    .NUM_THREADS(NUM_THREADS),
    .TS_W       (TS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rem_ts_i    (rem_ts_i),
    .snd_nack_i  (snd_nack_i),
    .rcv_nack_i  (rcv_nack_i),
    .txn_end_i   (txn_end_i),
    .cycle_o     (cycle_o),
    .trap_o      (trap_o),
    .wait_valid_o(wait_valid_o),
    .ts_err_o    (ts_err_o)
);

// File: tb/txn_age_arbiter_test.sv
module txn_age_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 4;
    localparam int TSW  = 8;
    localparam int PW   = 3;
    localparam int TW   = 2;
    localparam int LW   = PW + TW;
    localparam int WD_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst_n;
    logic [NT*TSW-1:0] local_ts;
    logic [TSW-1:0]    rem_ts;
    logic [PW-1:0]     rem_proc;
    logic [TW-1:0]     rem_tid;
    logic [NT-1:0]     rd_hit, wr_hit, txn_end;
    logic              snd, rcv;
    logic [TW-1:0]     rcv_tid;
    logic [NT-1:0]     cyc, trap, wvalid;
    logic [NT*LW-1:0]  wid;
    logic [NT*TSW-1:0] wts;
    logic              err;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_age_arbiter #(
        .NUM_THREADS(NT),
        .TS_W       (TSW),
        .PROC_W     (PW),
        .LOCAL_PROC (5)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .local_ts_i  (local_ts),
        .rem_ts_i    (rem_ts),
        .rem_proc_i  (rem_proc),
        .rem_tid_i   (rem_tid),
        .rd_hit_i    (rd_hit),
        .wr_hit_i    (wr_hit),
        .snd_nack_i  (snd),
        .rcv_nack_i  (rcv),
        .rcv_tid_i   (rcv_tid),
        .txn_end_i   (txn_end),
        .cycle_o     (cyc),
        .trap_o      (trap),
        .wait_valid_o(wvalid),
        .wait_id_o   (wid),
        .wait_ts_o   (wts),
        .ts_err_o    (err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_lts(input int a, input int b, input int c, input int d);
        local_ts = {TSW'(d), TSW'(c), TSW'(b), TSW'(a)};
    endtask

    // one event cycle; outputs are sampled just after the edge that registers it
    task automatic ev(input logic s, input logic r, input int rt_local,
                      input int rts, input int rp, input int rt,
                      input logic [NT-1:0] rd, input logic [NT-1:0] wr,
                      input logic [NT-1:0] en);
        @(negedge clk);
        snd = s; rcv = r; rcv_tid = TW'(rt_local);
        rem_ts = TSW'(rts); rem_proc = PW'(rp); rem_tid = TW'(rt);
        rd_hit = rd; wr_hit = wr; txn_end = en;
        @(posedge clk);
        #1;
        snd = 1'b0; rcv = 1'b0; rd_hit = '0; wr_hit = '0; txn_end = '0;
    endtask

    task automatic clear_all();
        ev(0, 0, 0, 1, 0, 0, '0, '0, '1);
    endtask

    task automatic t_reset();
        chk("R1 cycle", 64'(cyc), 0);
        chk("R1 trap", 64'(trap), 0);
        chk("R1 wvalid", 64'(wvalid), 0);
        chk("R1 wid", 64'(wid), 0);
        chk("R1 wts", 64'(wts), 0);
        chk("R1 err", 64'(err), 0);
    endtask

    task automatic t_ts_order();
        set_lts(10, 20, 30, 40);
        clear_all();
        ev(1, 0, 0, 25, 1, 0, 4'b1111, '0, '0);
        chk("R2 R5 ts order", 64'(cyc), 64'b1100);
        clear_all();
        chk("R9 end clears", 64'(cyc), 0);
    endtask

    task automatic t_hit_filter();
        set_lts(10, 20, 30, 40);
        clear_all();
        ev(1, 0, 0, 1, 1, 0, 4'b0001, 4'b0100, '0);
        chk("R5 hit filter", 64'(cyc), 64'b0101);
    endtask

    task automatic t_same_proc_tie();
        set_lts(50, 50, 50, 50);
        clear_all();
        ev(1, 0, 0, 50, 5, 1, 4'b1111, '0, '0);
        chk("R3 thread tie", 64'(cyc), 64'b1100);
    endtask

    task automatic t_proc_tie();
        set_lts(50, 50, 50, 50);
        clear_all();
        ev(1, 0, 0, 50, 3, 3, '0, 4'b1111, '0);
        chk("R4 lower proc older", 64'(cyc), 64'b1111);
        clear_all();
        ev(1, 0, 0, 50, 6, 0, 4'b1111, '0, '0);
        chk("R4 higher proc younger", 64'(cyc), 0);
    endtask

    task automatic t_wait_record();
        set_lts(10, 20, 30, 40);
        clear_all();
        ev(0, 1, 1, 7, 6, 3, '0, '0, '0);
        chk("R6 wvalid", 64'(wvalid), 64'b0010);
        chk("R6 wid", 64'(wid[1*LW +: LW]), 27);
        chk("R6 wts", 64'(wts[1*TSW +: TSW]), 7);
        chk("R7 no trap without flag", 64'(trap), 0);
    endtask

    task automatic t_trap();
        set_lts(10, 20, 40, 50);
        clear_all();
        ev(1, 0, 0, 10, 1, 0, 4'b0100, '0, '0);
        ev(0, 1, 2, 10, 1, 0, '0, '0, '0);
        chk("R7 trap raised", 64'(trap), 64'b0100);
        clear_all();
        ev(1, 0, 0, 10, 1, 0, 4'b0100, '0, '0);
        ev(0, 1, 2, 60, 1, 0, '0, '0, '0);
        chk("R7 younger no trap", 64'(trap), 0);
        clear_all();
        ev(1, 1, 3, 10, 1, 0, 4'b1000, '0, '0);
        chk("R7 same cycle cycle", 64'(cyc), 64'b1000);
        chk("R7 same cycle no trap", 64'(trap), 0);
        ev(0, 1, 3, 10, 1, 0, '0, '0, '0);
        chk("R7 later trap", 64'(trap), 64'b1000);
    endtask

    task automatic t_zero();
        set_lts(10, 20, 30, 40);
        clear_all();
        ev(1, 0, 0, 0, 1, 0, 4'b1111, '0, '0);
        chk("R8 err rem zero", 64'(err), 1);
        chk("R8 ignored", 64'(cyc), 0);
        ev(0, 0, 0, 5, 0, 0, '0, '0, '0);
        chk("R8 err one cycle", 64'(err), 0);
        set_lts(10, 0, 30, 40);
        ev(0, 1, 1, 5, 1, 0, '0, '0, '0);
        chk("R8 err local zero", 64'(err), 1);
        chk("R8 wait untouched", 64'(wvalid), 0);
        set_lts(10, 20, 30, 40);
    endtask

    task automatic t_end_priority();
        set_lts(10, 20, 30, 40);
        clear_all();
        ev(1, 0, 0, 1, 1, 0, 4'b0011, '0, 4'b0001);
        chk("R9 end wins", 64'(cyc), 64'b0010);
    endtask

    task automatic t_timing();
        set_lts(10, 20, 30, 40);
        clear_all();
        @(negedge clk);
        snd = 1'b1; rem_ts = 8'd1; rem_proc = 3'd1; rem_tid = 2'd0; rd_hit = 4'b0001;
        #1;
        chk("R10 not before edge", 64'(cyc), 0);
        @(posedge clk);
        #1;
        snd = 1'b0; rd_hit = '0;
        chk("R10 after edge", 64'(cyc), 64'b0001);
        ev(0, 0, 0, 1, 0, 0, '0, '0, '0);
        chk("R10 flag holds", 64'(cyc), 64'b0001);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; snd = 1'b0; rcv = 1'b0; rcv_tid = '0;
        rem_ts = '0; rem_proc = '0; rem_tid = '0;
        rd_hit = '0; wr_hit = '0; txn_end = '0; local_ts = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_ts_order();
        t_hit_filter();
        t_same_proc_tie();
        t_proc_tie();
        t_wait_record();
        t_trap();
        t_zero();
        t_end_priority();
        t_timing();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule